// File: doc/BRIEF.md
# Two-Operand ALU Stage with Flag Update

This block is the execute stage of a small register-based processor. Each cycle it may accept one operation together with two 16-bit operands and the current condition flags. The first operand is a pure source. The second operand is both a source and the destination. The block registers the outcome and presents it on the next cycle. The outcome is a result word, a write-enable for the destination register and the updated sign, zero, carry and overflow flags.

Seven operations are supported: register move, store pass-through, add, subtract, compare, bitwise AND and bitwise XOR. Compare performs the subtraction and updates every flag, but it never requests a destination write. A move copies the source and refreshes the sign and zero flags. The store pass-through hands the source word onward for a memory write and touches no flag. Operand fetch, register storage, memory access and branching all belong to neighbouring blocks.

Top module: `alu2op_stage`

## Requirements
- R1: `out_valid` equals the `in_valid` sampled on the previous rising clock edge, so every accepted operation appears exactly one cycle later.
- R2: Operation code 2 (add) yields `dst + src` modulo 2^16 and asserts `out_wr_en`. Carry is the bit-16 carry-out. Overflow is set when both addends share a sign that differs from the sign of the sum.
- R3: Operation code 3 (subtract) yields `dst - src`, computed as `dst + ~src + 1`, and asserts `out_wr_en`. Carry is the carry-out of that sum, meaning no borrow occurred. Overflow is set when `dst` and `src` have different signs and the result's sign differs from `dst`.
- R4: Operation code 4 (compare) updates all four flags exactly as subtract would and places the difference on `out_result`, but keeps `out_wr_en` low.
- R5: Operation code 0 (move) outputs `src` unchanged and asserts `out_wr_en`. It sets sign and zero from that value and passes carry and overflow through from `in_flags`.
- R6: Operation code 5 yields `dst & src` and operation code 6 yields `dst ^ src`. Both assert `out_wr_en`, update sign and zero, and pass carry and overflow through.
- R7: Operation code 1 (store pass-through) outputs `src`, keeps `out_wr_en` low and returns `in_flags` unchanged.
- R8: Operation code 7 is a no-op. It outputs `dst`, keeps `out_wr_en` low and returns `in_flags` unchanged.
- R9: The flag word is laid out as bit 3 sign (result bit 15), bit 2 zero (result is all zeros), bit 1 carry and bit 0 overflow.
- R10: In a cycle with `in_valid` low, `out_result` and `out_flags` keep their values on the next cycle, and `out_wr_en` is low.
- R11: A low `rst_n` clears all outputs at once, without waiting for a clock edge. Release passes through a two-stage synchronizer, so inputs are ignored on the first two rising edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 3 | Operation code (see R2 to R8) |
| in_src | input | 16 | Source operand |
| in_dst | input | 16 | Source/destination operand |
| in_flags | input | 4 | Current flags {sign, zero, carry, overflow} |
| out_valid | output | 1 | Registered outcome is valid |
| out_result | output | 16 | Result word |
| out_wr_en | output | 1 | Write the result to the destination register |
| out_flags | output | 4 | Updated flags {sign, zero, carry, overflow} |

## Verification
The arithmetic operations are tried on operand pairs chosen for specific purposes:
- Small values, which confirm operand order.
- Wrap-around to zero, which separates carry from zero.
- Sums that cross between 0x7FFF and 0x8000, which separate signed overflow from carry.
- Subtractions in both directions, which expose an inverted borrow.

Compare is driven with equal operands and with a borrowing pair, to show that the flags follow subtract while the write stays off. The move and logic operations are given incoming carry and overflow values that differ from what an arithmetic result would produce, so a design that recomputes them instead of passing them through is caught. A long run of random operands and operation codes, checked against an independent model, covers the combinations that the directed cases miss.

// File: rtl/alu2op_pkg.sv
package alu2op_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_CMP   = 3'd4,
    OP_AND   = 3'd5,
    OP_XOR   = 3'd6,
    OP_NOP   = 3'd7
  } alu_op_e;

  // Flag word: {sign, zero, carry, overflow}
  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu2op_rst_sync.sv
module alu2op_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/alu2op_addsub.sv
module alu2op_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dst,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   wide;

  always_comb begin
    addend   = subtract ? ~src : src;
    wide     = {1'b0, dst} + {1'b0, addend} + {{WIDTH{1'b0}}, subtract};
    sum      = wide[WIDTH-1:0];
    carry    = wide[WIDTH];
    overflow = (dst[MSB] == addend[MSB]) && (wide[MSB] != dst[MSB]);
  end

endmodule

// File: rtl/alu2op_logic.sv
module alu2op_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dst,
  input  logic             use_xor,
  output logic [WIDTH-1:0] y
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign y[g] = use_xor ? (dst[g] ^ src[g]) : (dst[g] & src[g]);
  end

endmodule

// File: rtl/alu2op_stage.sv
module alu2op_stage
  import alu2op_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [WIDTH-1:0]  in_src,
  input  logic [WIDTH-1:0]  in_dst,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  output logic [WIDTH-1:0]  out_result,
  output logic              out_wr_en,
  output logic [FLAG_W-1:0] out_flags
);

  localparam int MSB = WIDTH - 1;

  logic rst_sync_n;

  alu2op_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alu_op_e          op;
  logic             as_sub;
  logic [WIDTH-1:0] as_sum;
  logic             as_carry;
  logic             as_ovf;
  logic [WIDTH-1:0] lg_y;

  assign op     = alu_op_e'(in_op);
  assign as_sub = (op == OP_SUB) || (op == OP_CMP);

  alu2op_addsub #(.WIDTH(WIDTH)) u_addsub (
    .src      (in_src),
    .dst      (in_dst),
    .subtract (as_sub),
    .sum      (as_sum),
    .carry    (as_carry),
    .overflow (as_ovf)
  );

  alu2op_logic #(.WIDTH(WIDTH)) u_logic (
    .src     (in_src),
    .dst     (in_dst),
    .use_xor (op == OP_XOR),
    .y       (lg_y)
  );

  // Next-state
  logic [WIDTH-1:0] result_d;
  logic             wr_d;
  logic             upd_sz;
  alu_flags_t       flags_in;
  alu_flags_t       flags_d;

  assign flags_in = alu_flags_t'(in_flags);

  always_comb begin
    result_d = in_dst;
    wr_d     = 1'b0;
    upd_sz   = 1'b0;
    flags_d  = flags_in;
    unique case (op)
      OP_MOVE: begin
        result_d = in_src;
        wr_d     = 1'b1;
        upd_sz   = 1'b1;
      end
      OP_STORE: begin
        result_d = in_src;
      end
      OP_ADD, OP_SUB, OP_CMP: begin
        result_d  = as_sum;
        wr_d      = (op != OP_CMP);
        upd_sz    = 1'b1;
        flags_d.c = as_carry;
        flags_d.v = as_ovf;
      end
      OP_AND, OP_XOR: begin
        result_d = lg_y;
        wr_d     = 1'b1;
        upd_sz   = 1'b1;
      end
      OP_NOP: begin
        result_d = in_dst;
      end
      default: begin
        result_d = in_dst;
      end
    endcase
    if (upd_sz) begin
      flags_d.s = result_d[MSB];
      flags_d.z = ~|result_d;
    end
  end

  // Registers
  logic             valid_q;
  logic             wr_q;
  logic [WIDTH-1:0] result_q;
  alu_flags_t       flags_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      wr_q     <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      valid_q <= in_valid;
      wr_q    <= in_valid & wr_d;
      if (in_valid) begin
        result_q <= result_d;
        flags_q  <= flags_d;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_wr_en  = wr_q;
  assign out_result = result_q;
  assign out_flags  = flags_q;

endmodule

// File: rtl/alu2op_stage_chk.sv
module alu2op_stage_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             in_valid,
  input logic [2:0]       in_op,
  input logic [WIDTH-1:0] in_src,
  input logic [WIDTH-1:0] in_dst,
  input logic [3:0]       in_flags,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_result,
  input logic             out_wr_en,
  input logic [3:0]       out_flags
);

  logic [1:0] arm_q;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      arm_q <= 2'b00;
    end else begin
      arm_q <= {arm_q[0], 1'b1};
    end
  end

  logic armed;
  assign armed = arm_q[1];

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!armed)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_valid && in_op == 3'd2) |=>
      (out_result == WIDTH'($past(in_dst) + $past(in_src))) && out_wr_en);

  // R3
  sub_diff_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_valid && in_op == 3'd3) |=>
      (out_result == WIDTH'($past(in_dst) - $past(in_src))) && out_wr_en);

  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_valid && in_op == 3'd4) |=>
      !out_wr_en && (out_result == WIDTH'($past(in_dst) - $past(in_src))));

  // R5
  move_copy_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_valid && in_op == 3'd0) |=>
      (out_result == $past(in_src)) && out_wr_en &&
      (out_flags[1:0] == $past(in_flags[1:0])));

  // R6
  logic_keep_cv_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_valid && (in_op == 3'd5 || in_op == 3'd6)) |=>
      out_wr_en && (out_flags[1:0] == $past(in_flags[1:0])));

  // R7
  store_pass_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_valid && in_op == 3'd1) |=>
      !out_wr_en && (out_result == $past(in_src)) && (out_flags == $past(in_flags)));

  // R8
  nop_pass_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_valid && in_op == 3'd7) |=>
      !out_wr_en && (out_result == $past(in_dst)) && (out_flags == $past(in_flags)));

  // R9
  sign_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_valid && in_op != 3'd1 && in_op != 3'd7) |=>
      (out_flags[2] == (out_result == '0)) && (out_flags[3] == out_result[WIDTH-1]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    !in_valid |=> $stable(out_result) && $stable(out_flags) && !out_wr_en);

endmodule

bind alu2op_stage alu2op_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_src     (in_src),
  .in_dst     (in_dst),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_wr_en  (out_wr_en),
  .out_flags  (out_flags)
);

// File: tb/alu2op_stage_tb.sv
`timescale 1ns/1ps
module alu2op_stage_tb;

  localparam int NVEC = 17;
  localparam int NRND = 400;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [15:0] in_src;
  logic [15:0] in_dst;
  logic [3:0]  in_flags;
  logic        out_valid;
  logic [15:0] out_result;
  logic        out_wr_en;
  logic [3:0]  out_flags;

  int checks = 0;
  int fails  = 0;

  alu2op_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src(in_src), .in_dst(in_dst), .in_flags(in_flags),
    .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flags(out_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {op, src, dst, flags_in, result, wr_en, flags_out}; flags {S,Z,C,V}
  localparam logic [59:0] VEC [NVEC] = '{
    {3'd2, 16'h0001, 16'h0002, 4'h0, 16'h0003, 1'b1, 4'h0},
    {3'd2, 16'h0001, 16'hFFFF, 4'h0, 16'h0000, 1'b1, 4'h6},
    {3'd2, 16'h0001, 16'h7FFF, 4'h0, 16'h8000, 1'b1, 4'h9},
    {3'd2, 16'h8000, 16'h8000, 4'h0, 16'h0000, 1'b1, 4'h7},
    {3'd3, 16'h0001, 16'h0003, 4'h0, 16'h0002, 1'b1, 4'h2},
    {3'd3, 16'h0003, 16'h0001, 4'h0, 16'hFFFE, 1'b1, 4'h8},
    {3'd3, 16'h0001, 16'h8000, 4'h0, 16'h7FFF, 1'b1, 4'h3},
    {3'd4, 16'h1234, 16'h1234, 4'h0, 16'h0000, 1'b0, 4'h6},
    {3'd4, 16'h0005, 16'h0003, 4'h0, 16'hFFFE, 1'b0, 4'h8},
    {3'd0, 16'h8001, 16'h5555, 4'h3, 16'h8001, 1'b1, 4'hB},
    {3'd0, 16'h0000, 16'h5555, 4'h2, 16'h0000, 1'b1, 4'h6},
    {3'd5, 16'h0F0F, 16'h00FF, 4'h1, 16'h000F, 1'b1, 4'h1},
    {3'd5, 16'hF0F0, 16'h0F0F, 4'h2, 16'h0000, 1'b1, 4'h6},
    {3'd6, 16'hFFFF, 16'h00FF, 4'h0, 16'hFF00, 1'b1, 4'h8},
    {3'd6, 16'hAAAA, 16'hAAAA, 4'h9, 16'h0000, 1'b1, 4'h5},
    {3'd1, 16'hBEEF, 16'h1111, 4'hA, 16'hBEEF, 1'b0, 4'hA},
    {3'd7, 16'h0001, 16'h2222, 4'h5, 16'h2222, 1'b0, 4'h5}
  };

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R5 move";
      3'd1: return "R7 store";
      3'd2: return "R2 add";
      3'd3: return "R3 sub";
      3'd4: return "R4 cmp";
      3'd5: return "R6 and";
      3'd6: return "R6 xor";
      default: return "R8 nop";
    endcase
  endfunction

  // Independent model of R2..R9: returns {result, wr_en, flags}
  function automatic logic [20:0] model(input logic [2:0] op, input logic [15:0] s,
                                        input logic [15:0] d, input logic [3:0] f);
    logic [16:0] t;
    logic [15:0] r;
    logic        w;
    logic [3:0]  fo;
    fo = f;
    r  = d;
    w  = 1'b0;
    case (op)
      3'd0: begin r = s; w = 1'b1; end
      3'd1: begin r = s; end
      3'd2: begin
        t = {1'b0, d} + {1'b0, s};
        r = t[15:0]; w = 1'b1;
        fo[1] = t[16];
        fo[0] = (d[15] == s[15]) && (r[15] != d[15]);
      end
      3'd3, 3'd4: begin
        t = {1'b0, d} + {1'b0, ~s} + 17'd1;
        r = t[15:0]; w = (op == 3'd3);
        fo[1] = t[16];
        fo[0] = (d[15] != s[15]) && (r[15] != d[15]);
      end
      3'd5: begin r = d & s; w = 1'b1; end
      3'd6: begin r = d ^ s; w = 1'b1; end
      default: begin r = d; end
    endcase
    if (op != 3'd1 && op != 3'd7) begin
      fo[3] = r[15];
      fo[2] = (r == 16'h0000);
    end
    return {r, w, fo};
  endfunction

  task automatic check_out(input string tag, input logic vexp, input logic [15:0] rexp,
                           input logic wexp, input logic [3:0] fexp);
    checks++;
    if (out_valid !== vexp || out_result !== rexp || out_wr_en !== wexp || out_flags !== fexp) begin
      fails++;
      $display("FAIL %s: got valid=%b res=%h wr=%b flags=%h, expected valid=%b res=%h wr=%b flags=%h",
               tag, out_valid, out_result, out_wr_en, out_flags, vexp, rexp, wexp, fexp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [15:0] s,
                       input logic [15:0] d, input logic [3:0] f);
    in_valid = v; in_op = op; in_src = s; in_dst = d; in_flags = f;
  endtask

  // Watchdog
  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    drive(1'b0, 3'd0, 16'h0, 16'h0, 4'h0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared during reset
    check_out("R11 reset state", 1'b0, 16'h0000, 1'b0, 4'h0);

    // R11: inputs ignored while release passes through the synchronizer
    rst_n = 1'b1;
    drive(1'b1, 3'd2, 16'h0011, 16'h0022, 4'hF);
    repeat (2) @(negedge clk);
    check_out("R11 sync release", 1'b0, 16'h0000, 1'b0, 4'h0);
    drive(1'b0, 3'd0, 16'h0, 16'h0, 4'h0);
    repeat (3) @(negedge clk);

    // Directed vector table (R2..R9), back to back
    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VEC[i][59:57], VEC[i][56:41], VEC[i][40:25], VEC[i][24:21]);
      @(negedge clk);
      // R1 one cycle later; R9 flag layout
      check_out(op_tag(VEC[i][59:57]), 1'b1, VEC[i][20:5], VEC[i][4], VEC[i][3:0]);
    end

    // R10: idle cycles hold result and flags, no write
    drive(1'b1, 3'd2, 16'h1000, 16'h0234, 4'h0);
    @(negedge clk);
    check_out("R2 add before idle", 1'b1, 16'h1234, 1'b1, 4'h0);
    drive(1'b0, 3'd4, 16'hFFFF, 16'h0000, 4'hF);
    @(negedge clk);
    check_out("R10 idle hold 1", 1'b0, 16'h1234, 1'b0, 4'h0);
    drive(1'b0, 3'd6, 16'h5A5A, 16'h0F0F, 4'hA);
    @(negedge clk);
    check_out("R10 idle hold 2", 1'b0, 16'h1234, 1'b0, 4'h0);

    // Random operations against the model
    for (int i = 0; i < NRND; i++) begin
      logic [2:0]  op;
      logic [15:0] s, d;
      logic [3:0]  f;
      logic [20:0] e;
      op = 3'($urandom_range(0, 7));
      s  = 16'($urandom);
      d  = 16'($urandom);
      f  = 4'($urandom);
      if (i % 16 == 0) s = d;
      if (i % 16 == 1) s = 16'h8000;
      e = model(op, s, d, f);
      drive(1'b1, op, s, d, f);
      @(negedge clk);
      check_out(op_tag(op), 1'b1, e[20:5], e[4], e[3:0]);
    end

    // R11: asynchronous clear, observed before any clock edge
    drive(1'b0, 3'd0, 16'h0, 16'h0, 4'h0);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check_out("R11 async clear", 1'b0, 16'h0000, 1'b0, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1'b1, 3'd0, 16'h0000, 16'h7777, 4'h3);
    @(negedge clk);
    check_out("R5 move after reset", 1'b1, 16'h0000, 1'b1, 4'h7);
    drive(1'b0, 3'd0, 16'h0, 16'h0, 4'h0);
    @(negedge clk);
    check_out("R1 valid drops", 1'b0, 16'h0000, 1'b0, 4'h7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule